// File: doc/BRIEF.md
# Chain Conversion Readback Sequencer

This controller runs the two command sequences that a stacked battery-monitor chain needs from its host side. A conversion run broadcasts the read-pointer set-up and a conversion start to every device in the chain. It then waits for the conversions to finish, using a settle time that it works out from the acquisition-time code, the averaging code and the number of slave devices. After the wait it asks the serial shifter for one read-back frame per result channel. A discovery run resets the chain and locks its device addresses. It then reads frames until an all-zero word marks the end of the chain, and from that it reports how many slaves stand behind the master.

Commands leave the block as address, register, data and broadcast fields through a valid/ready handshake into a frame encoder. Each read request tells the shifter to clock in one frame while it sends its fixed idle word. Decoded response words come back with a CRC-good flag. The block holds at most one read outstanding at a time.

Top module: `chain_conv_seq`

## Requirements
- R1: While reset is held and after it is released, busy, done, cmd_valid and rd_req are low, err_code is 0 and disc_count is 0.
- R2: A conversion run issues exactly two broadcast commands (cmd_bcast=1, cmd_dev=0). The first writes register 0x1C with data 0x00. The second writes register 0x0D with data bit 3 set, the averaging code in bits 2:1, and bits 7:4 and bit 0 clear.
- R3: After the second conversion command is accepted, rd_req stays low for exactly W clock cycles and then rises. W = CLK_PER_US × (ceil(T/1000) + 5), where T = (A + 695)·12·N − A + 250·S ns. A is 465, 1010, 1460 or 1890 for acquisition codes 0 to 3, N is 1, 2, 4 or 8 for averaging codes 0 to 3, and S is slave_cnt captured at start.
- R4: A conversion run issues exactly (S + 1)·12 read requests and then pulses done with err_code 0.
- R5: A discovery run issues three broadcast commands in order. The first writes register 0x0E with bits 7, 4, 2 and 0 set and the acquisition code in bits 6:5. The second writes the same register and data with bit 7 clear. The third writes register 0x1C with data 0x38.
- R6: In discovery, an all-zero response at frame index n ≥ 1 ends the run with err_code 0 and disc_count = n − 1.
- R7: In discovery, a non-zero response that has rsp_crc_ok low, or whose bit-reversed field rsp_word[31:27] differs from its frame index, ends the run with err_code 1 and leaves disc_count unchanged.
- R8: If all MAX_SLAVES + 2 discovery frames are valid and non-zero, the run ends with err_code 2 and leaves disc_count unchanged.
- R9: An all-zero word at discovery frame index 0 ends the run with err_code 3 and leaves disc_count unchanged.
- R10: Start pulses that arrive while busy is high are ignored. If start_disc and start_conv are high in the same idle cycle, discovery runs.
- R11: While cmd_valid is high and cmd_ready is low, the command fields hold steady. cmd_valid and rd_req are never high together, and no new read is requested until the previous response has returned.
- R12: done is high for exactly one cycle, with busy high, at the end of a run. err_code keeps its value while the block is idle and is cleared only when the next run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_conv | input | 1 | Start a conversion run (taken when idle) |
| start_disc | input | 1 | Start a chain discovery run (taken when idle, wins a tie) |
| acq_code | input | 2 | Acquisition-time code, captured at start |
| avg_code | input | 2 | Averaging code, captured at start |
| slave_cnt | input | SL_W | Slaves behind the master, captured at start |
| cmd_valid | output | 1 | Command request valid |
| cmd_ready | input | 1 | Frame encoder accepts the command |
| cmd_dev | output | 5 | Target device address |
| cmd_reg | output | 6 | Target register |
| cmd_data | output | 8 | Register data |
| cmd_bcast | output | 1 | Write to all devices |
| rd_req | output | 1 | Request one read-back frame |
| rd_ready | input | 1 | Shifter accepts the read request |
| rsp_valid | input | 1 | Decoded response word present |
| rsp_word | input | 32 | Decoded response word |
| rsp_crc_ok | input | 1 | Response CRC matched |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 0 ok, 1 bad frame, 2 no terminator, 3 empty chain |
| disc_count | output | SL_W | Slave count from the last good discovery |

## Verification
The bench builds the block with CLK_PER_US = 2 and MAX_SLAVES = 7. The shorter microsecond keeps even the longest settle wait (acquisition code 3, averaging code 3, seven slaves) within a few hundred cycles, so the extreme corner of the wait formula can be checked exactly. With MAX_SLAVES = 7 the full nine-frame discovery limit is reachable, and so is a frame index of 8, whose reversed address pattern uses the upper bits. The encoder is stalled on every other cycle, which keeps the command-hold rule under load on every run.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int          CH_PER_DEV  = 12;
  localparam logic [5:0]  REG_CTRL_HI = 6'h0D;
  localparam logic [5:0]  REG_CTRL_LO = 6'h0E;
  localparam logic [5:0]  REG_RDPTR   = 6'h1C;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_FRAME = 2'd1,
    ERR_NOEND = 2'd2,
    ERR_EMPTY = 2'd3
  } seq_err_e;

  typedef enum logic {
    MODE_CONV = 1'b0,
    MODE_DISC = 1'b1
  } seq_mode_e;

  typedef enum logic [2:0] {
    DV_NEXT  = 3'd0,
    DV_END   = 3'd1,
    DV_BAD   = 3'd2,
    DV_NOEND = 3'd3,
    DV_EMPTY = 3'd4
  } disc_verdict_e;

  typedef struct packed {
    logic [4:0] dev;
    logic [5:0] regaddr;
    logic [7:0] data;
    logic       bcast;
  } seq_cmd_t;

  // acquisition window length in ns for each code
  function automatic int unsigned acq_ns(input logic [1:0] code);
    case (code)
      2'd0:    return 465;
      2'd1:    return 1010;
      2'd2:    return 1460;
      default: return 1890;
    endcase
  endfunction

  function automatic int unsigned avg_num(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  // settle time in whole microseconds, guard time included
  function automatic int unsigned settle_us(input logic [1:0] acq,
                                            input logic [1:0] avg,
                                            input int unsigned slaves);
    int unsigned ns;
    ns = (acq_ns(acq) + 695) * CH_PER_DEV * avg_num(avg)
         - acq_ns(acq) + 250 * slaves;
    return (ns + 999) / 1000 + 5;
  endfunction

  function automatic logic [4:0] bitrev5(input logic [4:0] v);
    return {v[0], v[1], v[2], v[3], v[4]};
  endfunction

endpackage

// File: rtl/seq_cmd_table.sv
module seq_cmd_table
  import seq_pkg::*;
(
  input  seq_mode_e  mode,
  input  logic [1:0] idx,
  input  logic [1:0] acq,
  input  logic [1:0] avg,
  output seq_cmd_t   cmd,
  output logic       last
);
  // control-low field bits
  localparam logic [7:0] LO_RESET  = 8'h80;
  localparam logic [7:0] LO_MUST   = 8'h10;
  localparam logic [7:0] LO_LOCK   = 8'h04;
  localparam logic [7:0] LO_CHAIN  = 8'h01;

  logic [7:0] lo_base;
  logic [7:0] hi_conv;

  assign lo_base = LO_MUST | LO_LOCK | LO_CHAIN | {1'b0, acq, 5'b0};
  // inputs all (7:6=0), read all (5:4=0), start on select edge (3), averaging (2:1)
  assign hi_conv = {2'b00, 2'b00, 1'b1, avg, 1'b0};

  always_comb begin
    cmd.dev   = 5'd0;
    cmd.bcast = 1'b1;
    cmd.regaddr = REG_RDPTR;
    cmd.data  = 8'h00;
    last      = 1'b0;
    if (mode == MODE_CONV) begin
      case (idx)
        2'd0: begin
          cmd.regaddr = REG_RDPTR;
          cmd.data    = 8'h00;
        end
        default: begin
          cmd.regaddr = REG_CTRL_HI;
          cmd.data    = hi_conv;
          last        = 1'b1;
        end
      endcase
    end else begin
      case (idx)
        2'd0: begin
          cmd.regaddr = REG_CTRL_LO;
          cmd.data    = lo_base | LO_RESET;
        end
        2'd1: begin
          cmd.regaddr = REG_CTRL_LO;
          cmd.data    = lo_base;
        end
        default: begin
          cmd.regaddr = REG_RDPTR;
          cmd.data    = {REG_CTRL_LO, 2'b00};
          last        = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == W'(1));

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0)); // R3
  AST_TIMER_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0)); // R3
endmodule

// File: rtl/seq_disc_check.sv
module seq_disc_check
  import seq_pkg::*;
#(
  parameter int IW       = 4,
  parameter int LAST_IDX = 8
) (
  input  logic [31:0]   word,
  input  logic          crc_ok,
  input  logic [IW-1:0] idx,
  output disc_verdict_e verdict
);
  logic [4:0] addr_seen;
  logic       addr_ok;

  assign addr_seen = bitrev5(word[31:27]);
  assign addr_ok   = (32'(addr_seen) == 32'(idx));

  always_comb begin
    if (word == 32'd0)
      verdict = (idx == '0) ? DV_EMPTY : DV_END;
    else if (!crc_ok || !addr_ok)
      verdict = DV_BAD;
    else if (32'(idx) == LAST_IDX)
      verdict = DV_NOEND;
    else
      verdict = DV_NEXT;
  end
endmodule

// File: rtl/chain_conv_seq.sv
module chain_conv_seq
  import seq_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int MAX_SLAVES = 7,
  parameter int TIMER_W    = 16,
  localparam int SL_W      = $clog2(MAX_SLAVES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_conv,
  input  logic            start_disc,
  input  logic [1:0]      acq_code,
  input  logic [1:0]      avg_code,
  input  logic [SL_W-1:0] slave_cnt,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [4:0]      cmd_dev,
  output logic [5:0]      cmd_reg,
  output logic [7:0]      cmd_data,
  output logic            cmd_bcast,
  output logic            rd_req,
  input  logic            rd_ready,
  input  logic            rsp_valid,
  input  logic [31:0]     rsp_word,
  input  logic            rsp_crc_ok,
  output logic            busy,
  output logic            done,
  output logic [1:0]      err_code,
  output logic [SL_W-1:0] disc_count
);
  localparam int DISC_READS = MAX_SLAVES + 2;
  localparam int DI_W       = $clog2(DISC_READS + 1);
  localparam int RD_MAX     = (MAX_SLAVES + 1) * CH_PER_DEV;
  localparam int RC_W       = $clog2(RD_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_WAIT, ST_RDREQ, ST_RDWAIT, ST_FIN
  } st_e;

  st_e             state;
  seq_mode_e       mode;
  logic [1:0]      cmd_idx;
  logic [1:0]      acq_q, avg_q;
  logic [SL_W-1:0] slv_q;
  logic [RC_W-1:0] rd_cnt;
  logic [DI_W-1:0] disc_idx;
  seq_err_e        err_q;
  logic [SL_W-1:0] disc_q;

  // named internal events
  logic            start_take;
  logic            cmd_fire;
  logic            rd_fire;
  logic            rsp_take;
  logic            cmd_last;
  logic            timer_load;
  logic            wait_expire;
  logic [RC_W-1:0] rd_total;
  logic [TIMER_W-1:0] wait_cyc;
  seq_cmd_t        cur_cmd;
  disc_verdict_e   verdict;

  assign start_take = (state == ST_IDLE) && (start_conv || start_disc);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign rd_fire    = rd_req && rd_ready;
  assign rsp_take   = (state == ST_RDWAIT) && rsp_valid;
  assign timer_load = cmd_fire && cmd_last && (mode == MODE_CONV);
  assign rd_total   = RC_W'((32'(slv_q) + 1) * CH_PER_DEV);
  assign wait_cyc   = TIMER_W'(settle_us(acq_q, avg_q, 32'(slv_q)) * CLK_PER_US);

  seq_cmd_table u_table (
    .mode (mode),
    .idx  (cmd_idx),
    .acq  (acq_q),
    .avg  (avg_q),
    .cmd  (cur_cmd),
    .last (cmd_last)
  );

  seq_wait_timer #(.W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (wait_cyc),
    .expire   (wait_expire)
  );

  seq_disc_check #(.IW(DI_W), .LAST_IDX(DISC_READS - 1)) u_check (
    .word    (rsp_word),
    .crc_ok  (rsp_crc_ok),
    .idx     (disc_idx),
    .verdict (verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode     <= MODE_CONV;
      cmd_idx  <= '0;
      acq_q    <= '0;
      avg_q    <= '0;
      slv_q    <= '0;
      rd_cnt   <= '0;
      disc_idx <= '0;
      err_q    <= ERR_NONE;
      disc_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_take) begin
            state    <= ST_CMD;
            mode     <= start_disc ? MODE_DISC : MODE_CONV;
            cmd_idx  <= '0;
            acq_q    <= acq_code;
            avg_q    <= avg_code;
            slv_q    <= slave_cnt;
            rd_cnt   <= '0;
            disc_idx <= '0;
            err_q    <= ERR_NONE;
          end
        end
        ST_CMD: begin
          if (cmd_fire) begin
            if (cmd_last)
              state <= (mode == MODE_CONV) ? ST_WAIT : ST_RDREQ;
            else
              cmd_idx <= cmd_idx + 2'd1;
          end
        end
        ST_WAIT: begin
          if (wait_expire) state <= ST_RDREQ;
        end
        ST_RDREQ: begin
          if (rd_fire) state <= ST_RDWAIT;
        end
        ST_RDWAIT: begin
          if (rsp_take) begin
            if (mode == MODE_CONV) begin
              if (rd_cnt == rd_total - 1'b1) state <= ST_FIN;
              else begin
                rd_cnt <= rd_cnt + 1'b1;
                state  <= ST_RDREQ;
              end
            end else begin
              case (verdict)
                DV_NEXT: begin
                  disc_idx <= disc_idx + 1'b1;
                  state    <= ST_RDREQ;
                end
                DV_END: begin
                  disc_q <= SL_W'(disc_idx - 1'b1);
                  state  <= ST_FIN;
                end
                DV_BAD: begin
                  err_q <= ERR_FRAME;
                  state <= ST_FIN;
                end
                DV_NOEND: begin
                  err_q <= ERR_NOEND;
                  state <= ST_FIN;
                end
                default: begin
                  err_q <= ERR_EMPTY;
                  state <= ST_FIN;
                end
              endcase
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid  = (state == ST_CMD);
  assign cmd_dev    = cur_cmd.dev;
  assign cmd_reg    = cur_cmd.regaddr;
  assign cmd_data   = cur_cmd.data;
  assign cmd_bcast  = cur_cmd.bcast;
  assign rd_req     = (state == ST_RDREQ);
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_FIN);
  assign err_code   = err_q;
  assign disc_count = disc_q;

  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rd_req)); // R11
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable({cmd_dev, cmd_reg, cmd_data, cmd_bcast}))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_ERR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $stable(err_code)); // R12
  AST_COUNT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disc_count) |-> done); // R6
  AST_CONV_READS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && mode == MODE_CONV) |-> (rd_cnt < rd_total)); // R4
  AST_DISC_READS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && mode == MODE_DISC) |-> (32'(disc_idx) < DISC_READS)); // R8
  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(cmd_valid || rd_req)); // R1
endmodule

// File: tb/chain_conv_seq_tb.sv
module chain_conv_seq_tb;
  localparam int CPU  = 2;
  localparam int MAXS = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_conv = 1'b0, start_disc = 1'b0;
  logic [1:0] acq_code = '0, avg_code = '0;
  logic [2:0] slave_cnt = '0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [4:0] cmd_dev;
  logic [5:0] cmd_reg;
  logic [7:0] cmd_data;
  logic cmd_bcast, rd_req, rd_ready = 1'b1;
  logic rsp_valid = 1'b0;
  logic [31:0] rsp_word = '0;
  logic rsp_crc_ok = 1'b0;
  logic busy, done;
  logic [1:0] err_code;
  logic [2:0] disc_count;

  always #10 clk = ~clk;

  chain_conv_seq #(.CLK_PER_US(CPU), .MAX_SLAVES(MAXS), .TIMER_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_conv(start_conv), .start_disc(start_disc),
    .acq_code(acq_code), .avg_code(avg_code), .slave_cnt(slave_cnt),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dev(cmd_dev),
    .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cmd_bcast(cmd_bcast),
    .rd_req(rd_req), .rd_ready(rd_ready), .rsp_valid(rsp_valid),
    .rsp_word(rsp_word), .rsp_crc_ok(rsp_crc_ok), .busy(busy), .done(done),
    .err_code(err_code), .disc_count(disc_count));

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench-side model of the requirements
  function automatic int exp_wait(input int a, input int v, input int s);
    int tacq[4] = '{465, 1010, 1460, 1890};
    int nav, ns, us;
    nav = 1;
    for (int i = 0; i < v; i++) nav = nav * 2;
    ns = (tacq[a] + 695) * 12 * nav - tacq[a] + 250 * s;
    us = ns / 1000 + ((ns % 1000) != 0 ? 1 : 0) + 5;
    return us * CPU;
  endfunction

  function automatic logic [4:0] rev5(input logic [4:0] x);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = x[4 - i];
    return r;
  endfunction

  function automatic logic [32:0] good_frame(input int n);
    return {1'b1, rev5(5'(n)), 27'h0123456};
  endfunction

  // monitor / responder state
  logic [19:0] cmd_log[$];
  logic [32:0] rsp_q[$];
  int rd_count = 0, rsp_dly = 0, wait_cnt = 0, wait_meas = -1;
  bit wait_arm = 0, hold_pend = 0, stall = 0;
  logic [19:0] hold_val;
  int inv_bad = 0, hold_bad = 0, outst_bad = 0;

  always @(negedge clk) begin
    logic [32:0] r;
    logic [19:0] cur;
    cur = {cmd_dev, cmd_reg, cmd_data, cmd_bcast};
    rsp_valid = 1'b0;
    if (rsp_dly > 0) begin
      rsp_dly--;
      if (rsp_dly == 0) begin
        r = (rsp_q.size() > 0) ? rsp_q.pop_front() : {1'b1, 32'h0ABC_D123};
        rsp_valid = 1'b1;
        rsp_crc_ok = r[32];
        rsp_word = r[31:0];
      end
    end
    if (rst_n) begin
      if ((cmd_valid && rd_req) || (!busy && (cmd_valid || rd_req)) || (done && !busy)) begin
        inv_bad++;
        $display("FAIL R11 request exclusivity actual=%0b%0b%0b%0b expected=legal", cmd_valid, rd_req, busy, done);
      end
      if (hold_pend && (!cmd_valid || cur != hold_val)) begin
        hold_bad++;
        $display("FAIL R11 command hold actual=%0h expected=%0h", cur, hold_val);
      end
      if (wait_arm) begin
        if (rd_req) begin wait_meas = wait_cnt; wait_arm = 0; end
        else wait_cnt++;
      end
      stall = ~stall;
      cmd_ready = ~stall;
      hold_pend = cmd_valid && !cmd_ready;
      hold_val = cur;
      if (cmd_valid && cmd_ready) begin
        cmd_log.push_back(cur);
        if (cmd_reg == 6'h0D) begin wait_arm = 1; wait_cnt = 0; end
      end
      if (rd_req && rd_ready) begin
        if (rsp_dly != 0 || rsp_valid) begin
          outst_bad++;
          $display("FAIL R11 outstanding read actual=1 expected=0");
        end
        rd_count++;
        rsp_dly = 2;
      end
    end
  end

  int got_err, got_cnt;

  task automatic run(input bit c, input bit d, input int poke_at);
    cmd_log.delete();
    rd_count = 0; wait_meas = -1;
    @(negedge clk);
    start_conv = c; start_disc = d;
    @(negedge clk);
    start_conv = 0; start_disc = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) break;
      if (i == poke_at) begin start_conv = 1; start_disc = 1; end
      else begin start_conv = 0; start_disc = 0; end
      @(negedge clk);
    end
    start_conv = 0; start_disc = 0;
    chk(done === 1'b1, "R12 done reached", done, 1);
    got_err = err_code; got_cnt = disc_count;
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R12 done one cycle", {done, busy}, 0);
    repeat (3) @(negedge clk);
    chk(err_code == 2'(got_err), "R12 err held idle", err_code, got_err);
  endtask

  task automatic conv_case(input int a, input int v, input int s, input int poke);
    acq_code = 2'(a); avg_code = 2'(v); slave_cnt = 3'(s);
    run(1, 0, poke);
    chk(cmd_log.size() == 2, "R2 conv command count", cmd_log.size(), 2);
    if (cmd_log.size() == 2) begin
      chk(cmd_log[0] == {5'd0, 6'h1C, 8'h00, 1'b1}, "R2 read pointer cmd", cmd_log[0], {5'd0, 6'h1C, 8'h00, 1'b1});
      chk(cmd_log[1] == {5'd0, 6'h0D, 8'(8 + 2 * v), 1'b1}, "R2 control high cmd", cmd_log[1], {5'd0, 6'h0D, 8'(8 + 2 * v), 1'b1});
    end
    chk(wait_meas == exp_wait(a, v, s), "R3 settle wait", wait_meas, exp_wait(a, v, s));
    chk(rd_count == (s + 1) * 12, "R4 read count", rd_count, (s + 1) * 12);
    chk(got_err == 0, "R4 conv err", got_err, 0);
  endtask

  task automatic disc_cmds(input int a);
    logic [7:0] b;
    b = 8'h15 | 8'(a << 5);
    chk(cmd_log.size() == 3, "R5 disc command count", cmd_log.size(), 3);
    if (cmd_log.size() == 3) begin
      chk(cmd_log[0] == {5'd0, 6'h0E, b | 8'h80, 1'b1}, "R5 reset write", cmd_log[0], {5'd0, 6'h0E, b | 8'h80, 1'b1});
      chk(cmd_log[1] == {5'd0, 6'h0E, b, 1'b1}, "R5 lock write", cmd_log[1], {5'd0, 6'h0E, b, 1'b1});
      chk(cmd_log[2] == {5'd0, 6'h1C, 8'h38, 1'b1}, "R5 pointer write", cmd_log[2], {5'd0, 6'h1C, 8'h38, 1'b1});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && cmd_valid == 0 && rd_req == 0, "R1 reset outputs in reset", {busy, done, cmd_valid, rd_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(err_code == 0 && disc_count == 0 && busy == 0, "R1 reset state", {err_code, disc_count, busy}, 0);

    // conversion patterns, one with start pokes while busy (R10)
    conv_case(0, 0, 0, -1);
    conv_case(2, 1, 2, 10);
    conv_case(3, 3, 7, 200);
    conv_case(1, 2, 4, -1);

    // discovery: three devices
    acq_code = 2'd2;
    rsp_q.delete();
    for (int n = 0; n < 3; n++) rsp_q.push_back(good_frame(n));
    rsp_q.push_back(33'd0);
    run(0, 1, -1);
    disc_cmds(2);
    chk(got_err == 0, "R6 disc err", got_err, 0);
    chk(got_cnt == 2, "R6 disc count", got_cnt, 2);
    chk(rd_count == 4, "R6 disc reads", rd_count, 4);

    // zero first word
    acq_code = 2'd0;
    rsp_q.delete(); rsp_q.push_back(33'd0);
    run(0, 1, -1);
    disc_cmds(0);
    chk(got_err == 3, "R9 empty chain err", got_err, 3);
    chk(got_cnt == 2, "R9 count unchanged", got_cnt, 2);

    // wrong address at index 1
    rsp_q.delete(); rsp_q.push_back(good_frame(0)); rsp_q.push_back(good_frame(2));
    run(0, 1, -1);
    chk(got_err == 1, "R7 address mismatch err", got_err, 1);
    chk(got_cnt == 2, "R7 count unchanged", got_cnt, 2);

    // bad CRC at index 0
    rsp_q.delete(); rsp_q.push_back({1'b0, good_frame(0)[31:0]});
    run(0, 1, -1);
    chk(got_err == 1, "R7 crc err", got_err, 1);

    // single slave then full-chain valid case
    rsp_q.delete(); rsp_q.push_back(good_frame(0)); rsp_q.push_back(good_frame(1)); rsp_q.push_back(33'd0);
    run(0, 1, -1);
    chk(got_err == 0 && got_cnt == 1, "R6 one slave", {got_err, got_cnt}, 1);

    rsp_q.delete();
    for (int n = 0; n < MAXS + 2; n++) rsp_q.push_back(good_frame(n));
    run(0, 1, -1);
    chk(got_err == 2, "R8 no terminator err", got_err, 2);
    chk(rd_count == MAXS + 2, "R8 read limit", rd_count, MAXS + 2);
    chk(got_cnt == 1, "R8 count unchanged", got_cnt, 1);

    // both starts together: discovery wins
    rsp_q.delete(); rsp_q.push_back(good_frame(0)); rsp_q.push_back(33'd0);
    acq_code = 2'd1;
    run(1, 1, -1);
    disc_cmds(1);
    chk(got_cnt == 0 && got_err == 0, "R10 tie picks discovery", {got_err, got_cnt}, 0);

    chk(inv_bad == 0, "R11 exclusivity over run", inv_bad, 0);
    chk(hold_bad == 0, "R11 hold over run", hold_bad, 0);
    chk(outst_bad == 0, "R11 single outstanding", outst_bad, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule